// File: doc/BRIEF.md
# Single-Level Paged Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address using a 16-entry page table held inside the block. The upper four address bits pick a table entry and the lower twelve bits pass through unchanged as the offset within a 4 KB page. Each entry names one of eight physical frames and carries four status and control bits: present, read-only, modified and referenced. A supervisor port loads and inspects entries and can clear every referenced bit at once.

A request is presented for one cycle with an address and a write flag. On the following cycle the block reports one of three outcomes: a translated address, a page fault (the entry is not present), or a protection fault (a write to a read-only page). A page fault also returns the faulting virtual page number. On a successful access the hardware marks the entry referenced, and on a successful write it also marks the entry modified. The requester sees the outcome through a small state machine. Its states are ST_IDLE (no response), ST_HIT (translated), ST_PFAULT (page fault) and ST_PROT (protection fault). The state moves on every cycle: a request steers it to ST_HIT, ST_PFAULT or ST_PROT according to how the lookup classifies, and a cycle without a request returns it to ST_IDLE.

Top module: `page_xlate`

## Requirements
- R1: Each cycle with `req_valid` high gives a response in the next cycle: `rsp_valid` is high and exactly one of `rsp_ok`, `rsp_page_fault`, `rsp_prot_fault` is high. In a cycle after no request, `rsp_valid` and all three outcome flags are low. Back-to-back requests each get their own response.
- R2: The entry is selected by `req_vaddr[15:12]`. On a hit, `rsp_paddr` = {entry frame, `req_vaddr[11:0]`}. For example, page 0 mapped to frame 2 turns virtual 0 into physical 8192.
- R3: If the selected entry is not present, the response is a page fault. `rsp_paddr` is 0, `rsp_fault_vpn` equals `req_vaddr[15:12]`, and no status bit of any entry changes.
- R4: A read-only bit of 0 allows both reads and writes. A read-only bit of 1 still allows reads, which translate normally.
- R5: A write to a present, read-only page gives a protection fault. `rsp_paddr` is 0, and neither the modified bit nor the referenced bit of that entry changes.
- R6: A write that translates successfully sets the modified bit of its entry.
- R7: Any successful access sets the referenced bit of its entry. A successful read leaves the modified bit unchanged.
- R8: When `cfg_clr_ref` is high, every referenced bit is 0 after that edge. The exception is an entry hit by a lookup in the same cycle, whose referenced bit ends up set.
- R9: A supervisor write in the same cycle as a lookup has two effects. The lookup uses the entry contents from before the write. For the written entry, the supervisor data replaces any hardware status update from that cycle.
- R10: After reset, every entry reads as all zeros (not present) and the response state is ST_IDLE.
- R11: `cfg_rdata` shows the entry selected by `cfg_idx` in the same cycle, and `cfg_wdata` is stored when `cfg_we` is high. The entry bit layout is: [2:0] frame, [3] present, [4] read-only, [5] modified, [6] referenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 16 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_we | input | 1 | Supervisor entry write strobe |
| cfg_idx | input | 4 | Entry selected for supervisor write and read |
| cfg_wdata | input | 7 | Entry value to store (layout in R11) |
| cfg_clr_ref | input | 1 | Clear all referenced bits |
| cfg_rdata | output | 7 | Current value of entry `cfg_idx` |
| rsp_valid | output | 1 | A response is presented |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | 15 | Translated physical address, 0 on a fault |
| rsp_page_fault | output | 1 | Selected page not present |
| rsp_prot_fault | output | 1 | Write to a read-only page |
| rsp_fault_vpn | output | 4 | Faulting virtual page number on a page fault, 0 otherwise |

## Verification
A corrupted table entry shows up on `cfg_rdata` in the same cycle the entry is selected, and in the outcome and address of any request to that page one cycle after the request. A wrong outcome state shows right after the edge that follows the request, as a wrong outcome flag or an address that is not cleared. A status bit that is wrongly set or wrongly kept shows only when the supervisor reads the entry back. For that reason the directed tests read back every entry that a hit, a fault, a reference clear or a same-cycle supervisor write could have touched.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HIT    = 2'd1,
        ST_PFAULT = 2'd2,
        ST_PROT   = 2'd3
    } pgx_state_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
    parameter int VPN_W   = 4,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   look_idx,
    output logic [FRAME_W-1:0] look_frame,
    output logic               look_present,
    output logic               look_ro,
    input  logic               upd_en,
    input  logic [VPN_W-1:0]   upd_idx,
    input  logic               upd_write,
    input  logic               cfg_we,
    input  logic [VPN_W-1:0]   cfg_idx,
    input  logic [FRAME_W+3:0] cfg_wdata,
    input  logic               cfg_clr_ref,
    output logic [FRAME_W+3:0] cfg_rdata
);
    localparam int N_ENT = 1 << VPN_W;
    localparam int EW    = FRAME_W + 4;
    localparam int PRS_B = FRAME_W;
    localparam int RO_B  = FRAME_W + 1;
    localparam int MOD_B = FRAME_W + 2;
    localparam int REF_B = FRAME_W + 3;

    logic [EW-1:0] ent_w [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        localparam logic [VPN_W-1:0] IDX = VPN_W'(i);
        logic [EW-1:0] e_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                e_q <= '0;
            end else if (cfg_we && cfg_idx == IDX) begin
                e_q <= cfg_wdata;
            end else begin
                if (cfg_clr_ref) e_q[REF_B] <= 1'b0;
                if (upd_en && upd_idx == IDX) begin
                    e_q[REF_B] <= 1'b1;
                    if (upd_write) e_q[MOD_B] <= 1'b1;
                end
            end
        end

        assign ent_w[i] = e_q;

        // R6: a successful write leaves its entry marked modified
        a_r6_write_marks_mod: assert property (@(posedge clk) disable iff (rst)
            (upd_en && upd_write && upd_idx == IDX && !(cfg_we && cfg_idx == IDX))
            |=> e_q[MOD_B]);

        // R8: a reference clear empties the bit unless the entry was hit or rewritten
        a_r8_clear_ref: assert property (@(posedge clk) disable iff (rst)
            (cfg_clr_ref && !(upd_en && upd_idx == IDX) && !(cfg_we && cfg_idx == IDX))
            |=> !e_q[REF_B]);
    end

    always_comb begin
        look_frame   = ent_w[look_idx][FRAME_W-1:0];
        look_present = ent_w[look_idx][PRS_B];
        look_ro      = ent_w[look_idx][RO_B];
        cfg_rdata    = ent_w[cfg_idx];
    end
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
    import pgx_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic                       req_write,
    output logic [VA_W-OFF_W-1:0]      look_idx,
    input  logic [FRAME_W-1:0]         look_frame,
    input  logic                       look_present,
    input  logic                       look_ro,
    output logic                       upd_en,
    output logic [VA_W-OFF_W-1:0]      upd_idx,
    output logic                       upd_write,
    output logic                       rsp_valid,
    output logic                       rsp_ok,
    output logic [FRAME_W+OFF_W-1:0]   rsp_paddr,
    output logic                       rsp_page_fault,
    output logic                       rsp_prot_fault,
    output logic [VA_W-OFF_W-1:0]      rsp_fault_vpn
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = FRAME_W + OFF_W;

    pgx_state_e        state_q, state_d;
    logic [VPN_W-1:0]  vpn;
    logic [PA_W-1:0]   paddr_q;
    logic [VPN_W-1:0]  vpn_q;

    assign vpn      = req_vaddr[VA_W-1:OFF_W];
    assign look_idx = vpn;

    // classification of the request into the next state
    always_comb begin
        if (!req_valid)                state_d = ST_IDLE;
        else if (!look_present)        state_d = ST_PFAULT;
        else if (req_write && look_ro) state_d = ST_PROT;
        else                           state_d = ST_HIT;
        upd_en    = (state_d == ST_HIT);
        upd_idx   = vpn;
        upd_write = req_write;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // captured request data
    always_ff @(posedge clk) begin
        if (rst) begin
            paddr_q <= '0;
            vpn_q   <= '0;
        end else if (req_valid) begin
            paddr_q <= {look_frame, req_vaddr[OFF_W-1:0]};
            vpn_q   <= vpn;
        end
    end

    // outputs decoded from the state
    always_comb begin
        rsp_valid      = 1'b0;
        rsp_ok         = 1'b0;
        rsp_paddr      = '0;
        rsp_page_fault = 1'b0;
        rsp_prot_fault = 1'b0;
        rsp_fault_vpn  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_ok    = 1'b1;
                rsp_paddr = paddr_q;
            end
            ST_PFAULT: begin
                rsp_valid      = 1'b1;
                rsp_page_fault = 1'b1;
                rsp_fault_vpn  = vpn_q;
            end
            ST_PROT: begin
                rsp_valid      = 1'b1;
                rsp_prot_fault = 1'b1;
            end
        endcase
    end

    // R5: a protection fault only answers a write request
    a_r5_prot_on_write: assert property (@(posedge clk) disable iff (rst)
        rsp_prot_fault |-> $past(req_write));
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic                      req_write,
    input  logic                      cfg_we,
    input  logic [VA_W-OFF_W-1:0]     cfg_idx,
    input  logic [FRAME_W+3:0]        cfg_wdata,
    input  logic                      cfg_clr_ref,
    output logic [FRAME_W+3:0]        cfg_rdata,
    output logic                      rsp_valid,
    output logic                      rsp_ok,
    output logic [FRAME_W+OFF_W-1:0]  rsp_paddr,
    output logic                      rsp_page_fault,
    output logic                      rsp_prot_fault,
    output logic [VA_W-OFF_W-1:0]     rsp_fault_vpn
);
    localparam int VPN_W = VA_W - OFF_W;

    logic [VPN_W-1:0]   look_idx;
    logic [FRAME_W-1:0] look_frame;
    logic               look_present;
    logic               look_ro;
    logic               upd_en;
    logic [VPN_W-1:0]   upd_idx;
    logic               upd_write;

    pgx_table #(.VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .look_idx     (look_idx),
        .look_frame   (look_frame),
        .look_present (look_present),
        .look_ro      (look_ro),
        .upd_en       (upd_en),
        .upd_idx      (upd_idx),
        .upd_write    (upd_write),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_wdata    (cfg_wdata),
        .cfg_clr_ref  (cfg_clr_ref),
        .cfg_rdata    (cfg_rdata)
    );

    pgx_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .look_idx       (look_idx),
        .look_frame     (look_frame),
        .look_present   (look_present),
        .look_ro        (look_ro),
        .upd_en         (upd_en),
        .upd_idx        (upd_idx),
        .upd_write      (upd_write),
        .rsp_valid      (rsp_valid),
        .rsp_ok         (rsp_ok),
        .rsp_paddr      (rsp_paddr),
        .rsp_page_fault (rsp_page_fault),
        .rsp_prot_fault (rsp_prot_fault),
        .rsp_fault_vpn  (rsp_fault_vpn)
    );

    // R1: a response appears exactly one cycle after each request
    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R2: a hit keeps the offset of the request
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        rsp_ok |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R3: a page fault names the page of the request
    a_r3_fault_vpn: assert property (@(posedge clk) disable iff (rst)
        rsp_page_fault |-> (rsp_fault_vpn == $past(req_vaddr[VA_W-1:OFF_W])));
endmodule

// File: tb/tb_page_xlate.sv
module tb_page_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [6:0]  cfg_wdata = '0;
    logic        cfg_clr_ref = 1'b0;
    logic [6:0]  cfg_rdata;
    logic        rsp_valid, rsp_ok, rsp_page_fault, rsp_prot_fault;
    logic [14:0] rsp_paddr;
    logic [3:0]  rsp_fault_vpn;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    page_xlate dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_clr_ref(cfg_clr_ref), .cfg_rdata(cfg_rdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .rsp_fault_vpn(rsp_fault_vpn)
    );

    function automatic logic [6:0] mk(input logic [2:0] frm, input logic prs,
                                      input logic ro, input logic md, input logic rf);
        return {rf, md, ro, prs, frm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // response flags packed as {valid, ok, pfault, prot}
    function automatic logic [3:0] flags();
        return {rsp_valid, rsp_ok, rsp_page_fault, rsp_prot_fault};
    endfunction

    task automatic do_req(input logic [15:0] va, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic cfg_wr(input logic [3:0] idx, input logic [6:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [6:0] v);
        cfg_idx = idx;
        #1;
        v = cfg_rdata;
    endtask

    task automatic t_reset();
        logic [6:0] v;
        check("R10 idle after reset", {28'd0, flags()}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            check("R10 R11 entry cleared", {25'd0, v}, 32'h0);
        end
    endtask

    task automatic t_absent();
        logic [6:0] v;
        do_req(16'h7ABC, 1'b0);
        check("R3 page fault flags", {28'd0, flags()}, 32'b1010);
        check("R3 fault vpn", {28'd0, rsp_fault_vpn}, 32'h7);
        check("R3 no address", {17'd0, rsp_paddr}, 32'h0);
        rd(4'd7, v);
        check("R3 entry untouched", {25'd0, v}, 32'h0);
    endtask

    task automatic t_basic();
        logic [6:0] v;
        cfg_wr(4'd0, mk(3'd2, 1'b1, 1'b0, 1'b0, 1'b0));
        rd(4'd0, v);
        check("R11 readback", {25'd0, v}, {25'd0, mk(3'd2, 1'b1, 1'b0, 1'b0, 1'b0)});
        do_req(16'h0000, 1'b0);
        check("R1 hit flags", {28'd0, flags()}, 32'b1100);
        check("R2 page0 frame2", {17'd0, rsp_paddr}, 32'd8192);
        rd(4'd0, v);
        check("R7 read sets ref only", {25'd0, v}, {25'd0, mk(3'd2, 1'b1, 1'b0, 1'b0, 1'b1)});
        @(negedge clk);
        check("R1 idle without request", {28'd0, flags()}, 32'h0);
        do_req(16'h0123, 1'b1);
        check("R4 write to rw page ok", {28'd0, flags()}, 32'b1100);
        check("R2 write address", {17'd0, rsp_paddr}, 32'h2123);
        rd(4'd0, v);
        check("R6 write sets modified", {25'd0, v}, {25'd0, mk(3'd2, 1'b1, 1'b0, 1'b1, 1'b1)});
    endtask

    task automatic t_readonly();
        logic [6:0] v;
        cfg_wr(4'd5, mk(3'd7, 1'b1, 1'b1, 1'b0, 1'b0));
        do_req(16'h5FFF, 1'b0);
        check("R4 read of ro page ok", {28'd0, flags()}, 32'b1100);
        check("R4 ro read address", {17'd0, rsp_paddr}, 32'h7FFF);
        rd(4'd5, v);
        check("R7 ro read sets ref", {25'd0, v}, {25'd0, mk(3'd7, 1'b1, 1'b1, 1'b0, 1'b1)});
        do_req(16'h5004, 1'b1);
        check("R5 protection fault flags", {28'd0, flags()}, 32'b1001);
        check("R5 no address", {17'd0, rsp_paddr}, 32'h0);
        rd(4'd5, v);
        check("R5 status unchanged", {25'd0, v}, {25'd0, mk(3'd7, 1'b1, 1'b1, 1'b0, 1'b1)});
    endtask

    task automatic t_clear_ref();
        logic [6:0] v;
        cfg_wr(4'd9, mk(3'd4, 1'b1, 1'b0, 1'b0, 1'b0));
        do_req(16'h9000, 1'b0);
        @(negedge clk);
        cfg_clr_ref = 1'b1;
        req_valid = 1'b1; req_vaddr = 16'h0010; req_write = 1'b0;
        @(negedge clk);
        cfg_clr_ref = 1'b0; req_valid = 1'b0;
        rd(4'd0, v);
        check("R8 same-cycle hit keeps ref", {25'd0, v}, {25'd0, mk(3'd2, 1'b1, 1'b0, 1'b1, 1'b1)});
        rd(4'd9, v);
        check("R8 ref cleared page9", {25'd0, v}, {25'd0, mk(3'd4, 1'b1, 1'b0, 1'b0, 1'b0)});
        rd(4'd5, v);
        check("R8 ref cleared page5", {25'd0, v}, {25'd0, mk(3'd7, 1'b1, 1'b1, 1'b0, 1'b0)});
    endtask

    task automatic t_same_cycle();
        logic [6:0] v;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd3; cfg_wdata = mk(3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        req_valid = 1'b1; req_vaddr = 16'h3010; req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R9 lookup sees old entry", {28'd0, flags()}, 32'b1010);
        rd(4'd3, v);
        check("R9 written entry stored", {25'd0, v}, {25'd0, mk(3'd1, 1'b1, 1'b0, 1'b0, 1'b0)});
        do_req(16'h3010, 1'b0);
        check("R9 later lookup uses new entry", {17'd0, rsp_paddr}, 32'h1010);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd0; cfg_wdata = mk(3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
        req_valid = 1'b1; req_vaddr = 16'h0ABC; req_write = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        check("R9 old frame used", {17'd0, rsp_paddr}, 32'h2ABC);
        rd(4'd0, v);
        check("R9 supervisor data wins", {25'd0, v}, {25'd0, mk(3'd6, 1'b1, 1'b0, 1'b0, 1'b0)});
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'h9001; req_write = 1'b0;
        @(negedge clk);
        check("R1 first of pair", {28'd0, flags()}, 32'b1100);
        check("R2 first of pair address", {17'd0, rsp_paddr}, 32'h4001);
        req_vaddr = 16'hE000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 second of pair", {28'd0, flags()}, 32'b1010);
        check("R3 second of pair vpn", {28'd0, rsp_fault_vpn}, 32'hE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_absent();
        t_basic();
        t_readonly();
        t_clear_ref();
        t_same_cycle();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule